// File: doc/BRIEF.md
# Selectable Card Transfer Clock Generator

This block derives the serial clock for a memory-card interface from the system clock. Software sets it up through two byte-wide registers on a small write/read port. The control register holds a clock-on bit and a 3-bit rate code. The rate code picks one of five fixed ratios: /100, /8, /4, /2 or the undivided system clock. A second register holds a pin-enable bit, which is driven out to the pad logic and also gates the card clock.

The /100 rate is the slow rate used while cards are identified over open-drain lines. The undivided rate is the fastest and is meant for a 20 MHz system clock. The even ratios come from a toggling counter with a 50% duty cycle. The undivided rate instead gates the system clock through an enable that is registered on the falling edge.

A new rate or on/off setting takes effect only while the divided output is low. A high phase already in progress always runs to its full length. Every start or restart begins with a full low phase of the new rate. A rate code of 101, 110 or 111 is stored and reads back as written, but it holds the clock low and raises an error flag.

Top module: `card_clk_gen`

## Requirements
- R1: After reset, both registers read 0x00, the rate code is 000, the clock is off, and card_clk_o, pin_en_o and sel_err_o are low.
- R2: The control register is at address 0. Bit 7 is clock-on and bits 2:0 are the rate code. Bits 6:3 ignore writes and read as 0.
- R3: The pin-enable register is at address 1. Bit 0 is stored and drives pin_en_o. Bits 7:1 read as 0.
- R4: With clock-on clear, card_clk_o stays low. Clearing it during a high phase lets that phase finish at full length, then the output stays low.
- R5: Rate codes 000, 001, 010 and 011 give a card clock period of 100, 8, 4 and 2 system cycles, with a high time of 50, 4, 2 and 1 cycles.
- R6: Rate code 100 makes card_clk_o follow the system clock, one card rising edge per system cycle.
- R7: Rate codes 101, 110 and 111 keep card_clk_o low and set sel_err_o. The code reads back unchanged.
- R8: A change of rate written during a high phase does not shorten that phase. The new rate applies from the following low phase.
- R9: After the clock is switched on, the first rising edge comes after a full low phase. With rate 001, the output is sampled low at the 5 falling edges after the write edge and first seen high at the 6th.
- R10: With the pin-enable bit clear, card_clk_o is held low at every rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | Register select: 0 control, 1 pin enable |
| wr_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed register |
| card_clk_o | output | 1 | Card transfer clock |
| pin_en_o | output | 1 | Interface pin enable |
| sel_err_o | output | 1 | Prohibited rate code is stored |

## Verification
Assertions check on every cycle that:
- register writes land in the right fields;
- the active setting never changes during a high phase;
- an off or prohibited setting never lets a low output rise;
- a new run always starts from a low output;
- the fast gate and the toggle output are never active together;
- a cleared pin enable forces the card clock low.

Only the bench scenarios can show the exact periods and high times of each ratio, the length of the first low phase after switch-on, and that a high phase cut by an off or rate-change write keeps its full length. They also show that the undivided rate gives one card edge per system cycle.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;
  localparam int SEL_W = 3;

  localparam logic [SEL_W-1:0] SEL_SLOW = 3'd0;
  localparam logic [SEL_W-1:0] SEL_MID  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_QTR  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_HALF = 3'd3;
  localparam logic [SEL_W-1:0] SEL_FAST = 3'd4;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_PIN  = 1'b1;

  typedef struct packed {
    logic             on;
    logic [SEL_W-1:0] sel;
  } clk_cfg_t;

  function automatic logic sel_bad(input logic [SEL_W-1:0] s);
    return s > SEL_FAST;
  endfunction

  function automatic logic sel_toggle(input logic [SEL_W-1:0] s);
    return s <= SEL_HALF;
  endfunction
endpackage

// File: rtl/card_clk_regs.sv
module card_clk_regs
  import card_clk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output clk_cfg_t          cfg_o,
  output logic              pin_en_o,
  output logic              sel_err_o
);
  localparam int ON_BIT = DATA_W - 1;
  localparam int RSV_W  = DATA_W - 1 - SEL_W;

  clk_cfg_t ctrl_q;
  logic     pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      pin_q  <= 1'b0;
    end else if (wr_i) begin
      if (addr_i == ADDR_CTRL) ctrl_q <= {wdata_i[ON_BIT], wdata_i[SEL_W-1:0]};
      else                     pin_q  <= wdata_i[0];
    end
  end

  // reserved write bits are dropped
  logic unused_rsv;
  assign unused_rsv = ^wdata_i[ON_BIT-1:SEL_W];

  always_comb begin
    if (addr_i == ADDR_CTRL) rdata_o = {ctrl_q.on, {RSV_W{1'b0}}, ctrl_q.sel};
    else                     rdata_o = {{(DATA_W-1){1'b0}}, pin_q};
  end

  assign cfg_o     = ctrl_q;
  assign pin_en_o  = pin_q;
  assign sel_err_o = sel_bad(ctrl_q.sel);

  // R2
  ctrl_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_CTRL) |=>
      (cfg_o == {$past(wdata_i[ON_BIT]), $past(wdata_i[SEL_W-1:0])}));

  // R3
  pin_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_PIN) |=> (pin_en_o == $past(wdata_i[0])));

  // R2
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == ADDR_CTRL) |=> $stable(cfg_o));
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
  import card_clk_pkg::*;
#(
  parameter int SLOW_DIV = 100,
  parameter int MID_DIV  = 8,
  parameter int QTR_DIV  = 4,
  parameter int HALF_DIV = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  clk_cfg_t pend_i,
  output logic     tog_o,
  output clk_cfg_t act_o
);
  localparam int CNT_W = $clog2(SLOW_DIV / 2 + 1);

  clk_cfg_t         act_q;
  logic             tog_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_last;
  logic             run;

  always_comb begin
    unique case (act_q.sel)
      SEL_SLOW: half_last = CNT_W'(SLOW_DIV / 2 - 1);
      SEL_MID:  half_last = CNT_W'(MID_DIV / 2 - 1);
      SEL_QTR:  half_last = CNT_W'(QTR_DIV / 2 - 1);
      SEL_HALF: half_last = CNT_W'(HALF_DIV / 2 - 1);
      default:  half_last = '0;
    endcase
  end

  assign run = act_q.on && sel_toggle(act_q.sel);

  // settings are adopted only while the output is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      tog_q <= 1'b0;
      cnt_q <= '0;
    end else if (!tog_q && (pend_i != act_q)) begin
      act_q <= pend_i;
      cnt_q <= '0;
    end else if (run) begin
      if (cnt_q == half_last) begin
        cnt_q <= '0;
        tog_q <= ~tog_q;
        if (tog_q) act_q <= pend_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
      tog_q <= 1'b0;
    end
  end

  assign tog_o = tog_q;
  assign act_o = act_q;

  // R8
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tog_q && $past(tog_q)) |-> $stable(act_q));

  // R4
  off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_i.on && !tog_q) |=> !tog_q);

  // R7
  bad_sel_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_bad(pend_i.sel) && !tog_q) |=> !tog_q);

  // R9
  start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run) |-> !tog_q);
endmodule

// File: rtl/card_clk_out.sv
module card_clk_out
  import card_clk_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     pin_en_i,
  input  logic     tog_i,
  input  clk_cfg_t act_i,
  output logic     card_clk_o
);
  logic gate_q;

  // enable changes only while clk_i is low, so the gated clock has no runts
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= act_i.on && (act_i.sel == SEL_FAST);
  end

  assign card_clk_o = pin_en_i && (tog_i || (clk_i && gate_q));

  // R6
  fast_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_q |-> !tog_i);

  // R10
  pin_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_en_i |-> !card_clk_o);
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
  import card_clk_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SLOW_DIV = 100,
  parameter int MID_DIV  = 8,
  parameter int QTR_DIV  = 4,
  parameter int HALF_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              card_clk_o,
  output logic              pin_en_o,
  output logic              sel_err_o
);
  clk_cfg_t cfg, act;
  logic     tog;

  card_clk_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .wdata_i, .rdata_o,
    .cfg_o(cfg), .pin_en_o, .sel_err_o
  );

  card_clk_div #(
    .SLOW_DIV(SLOW_DIV), .MID_DIV(MID_DIV), .QTR_DIV(QTR_DIV), .HALF_DIV(HALF_DIV)
  ) u_div (
    .clk_i, .rst_ni, .pend_i(cfg), .tog_o(tog), .act_o(act)
  );

  card_clk_out u_out (
    .clk_i, .rst_ni, .pin_en_i(pin_en_o), .tog_i(tog), .act_i(act), .card_clk_o
  );
endmodule

// File: tb/card_clk_gen_tb.sv
`timescale 1ns/1ps
module card_clk_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       card_clk, pin_en, sel_err;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  card_clk_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .card_clk_o(card_clk), .pin_en_o(pin_en), .sel_err_o(sel_err)
  );

  // monitor sampled on falling edges
  int cyc = 0, hi_run = 0, last_hi = 0, rises = 0, last_rise = 0, last_period = 0;
  logic prev = 1'b0;
  always @(negedge clk) begin
    if (card_clk) hi_run++;
    else begin
      if (prev) last_hi = hi_run;
      hi_run = 0;
    end
    if (card_clk && !prev) begin
      rises++;
      last_period = cyc - last_rise;
      last_rise = cyc;
    end
    prev = card_clk;
    cyc++;
  end

  int edges = 0;
  always @(posedge card_clk) edges++;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk);
    #1 wr = 1'b0;
  endtask

  task automatic rd_reg(input logic a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd_reg(1'b0, d); chk("R1 ctrl", d, 0);
    rd_reg(1'b1, d); chk("R1 pin", d, 0);
    chk("R1 clk", card_clk, 0);
    chk("R1 pin_en", pin_en, 0);
    chk("R1 err", sel_err, 0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr_reg(1'b0, 8'h7B);
    rd_reg(1'b0, d); chk("R2 rsvd", d, 8'h03);
    wr_reg(1'b0, 8'hFF);
    rd_reg(1'b0, d); chk("R2 all", d, 8'h87);
    wr_reg(1'b0, 8'h00);
    wr_reg(1'b1, 8'hFF);
    rd_reg(1'b1, d); chk("R3 read", d, 8'h01);
    chk("R3 pin_en", pin_en, 1);
  endtask

  task automatic t_ratios();
    int n [4] = '{100, 8, 4, 2};
    for (int s = 0; s < 4; s++) begin
      wr_reg(1'b0, 8'h80 | 8'(s));
      wait_neg(3 * n[s] + 10);
      chk($sformatf("R5 period sel%0d", s), last_period, n[s]);
      chk($sformatf("R5 high sel%0d", s), last_hi, n[s] / 2);
    end
  endtask

  task automatic t_fast();
    int e0;
    wr_reg(1'b0, 8'h84);
    wait_neg(10);
    e0 = edges;
    wait_neg(20);
    chk("R6 edges", edges - e0, 20);
  endtask

  task automatic t_bad();
    logic [7:0] d;
    int e0;
    for (int s = 5; s < 8; s++) begin
      wr_reg(1'b0, 8'h80 | 8'(s));
      wait_neg(4);
      e0 = edges;
      wait_neg(40);
      chk($sformatf("R7 edges sel%0d", s), edges - e0, 0);
      chk($sformatf("R7 err sel%0d", s), sel_err, 1);
      rd_reg(1'b0, d); chk($sformatf("R7 read sel%0d", s), d, 8'h80 | 8'(s));
    end
  endtask

  task automatic t_start();
    int lows = 0;
    wr_reg(1'b0, 8'h01);
    wait_neg(20);
    wr_reg(1'b0, 8'h81);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      #0.5;
      if (card_clk) break;
      lows++;
    end
    chk("R9 first low", lows, 5);
  endtask

  task automatic t_off_in_high();
    int r0, e0;
    wr_reg(1'b0, 8'h80);
    wait_neg(120);
    r0 = rises;
    while (rises == r0) @(negedge clk);
    wait_neg(10);
    wr_reg(1'b0, 8'h00);
    wait_neg(120);
    chk("R4 high kept", last_hi, 50);
    e0 = edges;
    wait_neg(150);
    chk("R4 stays low", edges - e0, 0);
    chk("R4 level", card_clk, 0);
  endtask

  task automatic t_change_in_high();
    int r0;
    wr_reg(1'b0, 8'h80);
    wait_neg(120);
    r0 = rises;
    while (rises == r0) @(negedge clk);
    wait_neg(10);
    wr_reg(1'b0, 8'h82);
    r0 = rises;
    while (rises == r0) @(negedge clk);
    chk("R8 high kept", last_hi, 50);
    wait_neg(20);
    chk("R8 new period", last_period, 4);
    chk("R8 new high", last_hi, 2);
  endtask

  task automatic t_pin_off();
    int e0;
    wr_reg(1'b0, 8'h83);
    wait_neg(10);
    wr_reg(1'b1, 8'h00);
    e0 = edges;
    wait_neg(20);
    chk("R10 slow edges", edges - e0, 0);
    chk("R10 pin_en", pin_en, 0);
    wr_reg(1'b0, 8'h84);
    wait_neg(5);
    e0 = edges;
    wait_neg(20);
    chk("R10 fast edges", edges - e0, 0);
    wr_reg(1'b1, 8'h01);
  endtask

  initial begin
    fork
      begin
        #3 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_regs();
        t_ratios();
        t_fast();
        t_bad();
        t_start();
        t_off_in_high();
        t_change_in_high();
        t_pin_off();
      end
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=done");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule